// File: doc/BRIEF.md
# Host Interface Interrupt Controller

This block produces every interrupt of a three-channel host mailbox interface: a keyboard channel, a mouse channel and a power-management channel. Toward the host it drives one IRQ line per channel. Toward the embedded core it drives four interrupt requests. These requests come from the buffer status flags of the keyboard and power-management mailboxes. Two byte-wide registers on the core's register bus configure the block. The first is an enable register. The second is an IRQ control register, which holds the manual line levels, an output polarity and an edge/level mode.

Each host IRQ line has two sources. When its enable bit is clear, firmware drives the line directly through a manual bit. When its enable bit is set, the line is generated automatically. A core write to that channel's output data register starts it. In level mode the line stays asserted until the host reads that output buffer. In pulse mode the line asserts for exactly one clock. The polarity bit is applied last and covers all three lines.

The core-side requests are simple gates. Each one follows a mailbox flag, qualified by its own enable bit.

Top module: `hiic_ctrl`

## Requirements
- R1: The enable register (address 0) resets to 00h. Bits 6:0 are read/write and bit 7 always reads 0. The bit meanings are: bit 0 keyboard host IRQ auto, bit 1 mouse host IRQ auto, bit 4 power-management host IRQ auto, bit 2 keyboard output-empty core request, bit 3 keyboard input-full core request, bit 5 power-management output-empty core request, bit 6 power-management input-full core request.
- R2: The IRQ control register (address 1) resets to 07h. Bits 2:0 are the manual levels for the keyboard, mouse and power-management lines, bit 3 is polarity and bit 4 is mode. Bits 7:5 ignore writes and read 0.
- R3: While a channel's auto-enable bit is 0, its host line `host_irq[i]` equals its manual bit XOR polarity. Index 0 is keyboard, 1 is mouse and 2 is power management.
- R4: In level mode (mode=0), a core write strobe on `core_odr_wr[i]` makes the auto source active from the next cycle. It stays active until a host read strobe `host_odr_rd[i]`, and reads inactive from the cycle after that read.
- R5: In pulse mode (mode=1), each core write strobe makes the auto source active for exactly the one following cycle.
- R6: Polarity=1 inverts all three host lines, in both manual and automatic use.
- R7: `core_irq[0]` (keyboard) and `core_irq[2]` (power management) are the output-empty requests. Each is high exactly when its enable bit is set and the channel's output-full flag is low. With the enable bit clear the request is held low.
- R8: `core_irq[1]` (keyboard) and `core_irq[3]` (power management) are the input-full requests. Each is high exactly when its enable bit is set and the channel's input-full flag is high.
- R9: If a core write and a host read strike the same channel in the same cycle, the write wins and the level-mode source stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 IRQ control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| core_odr_wr | input | 3 | Core write to output data register (kbd, mouse, pm) |
| host_odr_rd | input | 3 | Host read of output buffer (kbd, mouse, pm) |
| kbd_obf | input | 1 | Keyboard output buffer full flag |
| kbd_ibf | input | 1 | Keyboard input buffer full flag |
| pm_obf | input | 1 | Power-management output buffer full flag |
| pm_ibf | input | 1 | Power-management input buffer full flag |
| host_irq | output | 3 | Host IRQ lines (kbd, mouse, pm) |
| core_irq | output | 4 | Core requests: kbd empty, kbd full, pm empty, pm full |

## Verification
The bench targets three hazards. The first is the register edges: the reserved bits, the 07h control reset and the way a manual line shows its level straight after reset. If any of these is mishandled, the host lines start high or low wrongly. The second is auto mode. Here it checks that a level-mode line holds across idle cycles and drops only after the host read. It also checks that a pulse lasts exactly one cycle, and that a write colliding with a read is not lost. A design that lets the read win would silently drop an interrupt. The third is polarity in both manual and automatic use, together with the independent enables of the four core requests. A wrong bit mapping would route an interrupt to the wrong channel.

// File: rtl/hiic_pkg.sv
package hiic_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_HCH = 3;   // host channels: kbd, mouse, pm
    localparam int NUM_CRQ = 4;   // core requests

    // enable register bit positions
    localparam int EN_KBD_AUTO  = 0;
    localparam int EN_MSE_AUTO  = 1;
    localparam int EN_KBD_OBE   = 2;
    localparam int EN_KBD_IBF   = 3;
    localparam int EN_PM_AUTO   = 4;
    localparam int EN_PM_OBE    = 5;
    localparam int EN_PM_IBF    = 6;
    localparam int EN_BITS      = 7;

    // control register bit positions
    localparam int CTL_POL      = 3;
    localparam int CTL_MODE     = 4;
    localparam int CTL_BITS     = 5;

    localparam logic [EN_BITS-1:0]  EN_RESET  = '0;
    localparam logic [CTL_BITS-1:0] CTL_RESET = 5'b0_0111;

    typedef struct packed {
        logic               mode;    // 0 level, 1 pulse
        logic               pol;     // 0 active-high, 1 active-low
        logic [NUM_HCH-1:0] manual;
    } ctl_t;

    typedef struct packed {
        logic [EN_BITS-1:0] en;
        ctl_t               ctl;
    } regs_t;

endpackage

// File: rtl/hiic_regs.sv
module hiic_regs
    import hiic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [EN_BITS-1:0] en,
    output ctl_t               ctl
);

    regs_t st_d, st_q;
    logic  unused_wmsb;

    assign unused_wmsb = reg_wdata[REG_W-1];

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (reg_addr) begin
                st_d.ctl = ctl_t'(reg_wdata[CTL_BITS-1:0]);
            end else begin
                st_d.en = reg_wdata[EN_BITS-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en  <= EN_RESET;
            st_q.ctl <= ctl_t'(CTL_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (reg_addr) begin
            reg_rdata = {{(REG_W-CTL_BITS){1'b0}}, st_q.ctl};
        end else begin
            reg_rdata = {{(REG_W-EN_BITS){1'b0}}, st_q.en};
        end
    end

    assign en  = st_q.en;
    assign ctl = st_q.ctl;

endmodule

// File: rtl/hiic_host_irq.sv
module hiic_host_irq
    import hiic_pkg::*;
#(
    parameter int NCH = NUM_HCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] odr_wr,
    input  logic [NCH-1:0] odr_rd,
    input  logic [NCH-1:0] auto_en,
    input  logic [NCH-1:0] manual,
    input  logic           mode,
    input  logic           pol,
    output logic [NCH-1:0] irq
);

    typedef struct packed {
        logic [NCH-1:0] pend;    // level source: written, not yet read
        logic [NCH-1:0] pulse;   // pulse source: written last cycle
    } hst_t;

    hst_t st_d, st_q;
    logic [NCH-1:0] auto_src;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            // write has priority over a same-cycle read
            if (odr_wr[i]) begin
                st_d.pend[i] = 1'b1;
            end else if (odr_rd[i]) begin
                st_d.pend[i] = 1'b0;
            end
            st_d.pulse[i] = odr_wr[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_line
            assign auto_src[g] = mode ? st_q.pulse[g] : st_q.pend[g];
            assign irq[g]      = pol ^ (auto_en[g] ? auto_src[g] : manual[g]);
        end
    endgenerate

endmodule

// File: rtl/hiic_core_irq.sv
module hiic_core_irq
    import hiic_pkg::*;
(
    input  logic               kbd_obf,
    input  logic               kbd_ibf,
    input  logic               pm_obf,
    input  logic               pm_ibf,
    input  logic [NUM_CRQ-1:0] req_en,
    output logic [NUM_CRQ-1:0] req
);

    logic [NUM_CRQ-1:0] cond;

    always_comb begin
        cond[0] = !kbd_obf;
        cond[1] =  kbd_ibf;
        cond[2] = !pm_obf;
        cond[3] =  pm_ibf;
    end

    generate
        for (genvar g = 0; g < NUM_CRQ; g++) begin : g_req
            assign req[g] = req_en[g] & cond[g];
        end
    endgenerate

endmodule

// File: rtl/hiic_ctrl.sv
module hiic_ctrl
    import hiic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_HCH-1:0] core_odr_wr,
    input  logic [NUM_HCH-1:0] host_odr_rd,
    input  logic               kbd_obf,
    input  logic               kbd_ibf,
    input  logic               pm_obf,
    input  logic               pm_ibf,
    output logic [NUM_HCH-1:0] host_irq,
    output logic [NUM_CRQ-1:0] core_irq
);

    logic [EN_BITS-1:0] en;
    ctl_t               ctl;
    logic [NUM_HCH-1:0] auto_en;
    logic [NUM_CRQ-1:0] core_en;
    logic               irq_mode;
    logic               irq_pol;

    assign auto_en  = {en[EN_PM_AUTO], en[EN_MSE_AUTO], en[EN_KBD_AUTO]};
    assign core_en  = {en[EN_PM_IBF], en[EN_PM_OBE], en[EN_KBD_IBF], en[EN_KBD_OBE]};
    assign irq_mode = ctl.mode;
    assign irq_pol  = ctl.pol;

    hiic_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en        (en),
        .ctl       (ctl)
    );

    hiic_host_irq #(.NCH(NUM_HCH)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .odr_wr  (core_odr_wr),
        .odr_rd  (host_odr_rd),
        .auto_en (auto_en),
        .manual  (ctl.manual),
        .mode    (irq_mode),
        .pol     (irq_pol),
        .irq     (host_irq)
    );

    hiic_core_irq u_core (
        .kbd_obf (kbd_obf),
        .kbd_ibf (kbd_ibf),
        .pm_obf  (pm_obf),
        .pm_ibf  (pm_ibf),
        .req_en  (core_en),
        .req     (core_irq)
    );

endmodule

// File: rtl/hiic_ctrl_chk.sv
module hiic_ctrl_chk
    import hiic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_HCH-1:0] core_odr_wr,
    input  logic [NUM_HCH-1:0] host_odr_rd,
    input  logic [NUM_HCH-1:0] host_irq,
    input  logic [NUM_CRQ-1:0] core_irq,
    input  logic [NUM_HCH-1:0] auto_en,
    input  logic [NUM_CRQ-1:0] core_en,
    input  logic               irq_mode,
    input  logic               irq_pol
);

    p_en_msb_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> !reg_rdata[REG_W-1]);

    p_ctl_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr |-> (reg_rdata[REG_W-1:CTL_BITS] == '0));

    generate
        for (genvar g = 0; g < NUM_HCH; g++) begin : g_chk
            p_level_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (auto_en[g] && !irq_mode && !irq_pol && core_odr_wr[g] && !reg_wr)
                |=> host_irq[g]);
            p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (auto_en[g] && !irq_mode && !irq_pol && host_irq[g]
                 && !host_odr_rd[g] && !reg_wr) |=> host_irq[g]);
            p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (auto_en[g] && !irq_mode && !irq_pol && core_odr_wr[g]
                 && host_odr_rd[g] && !reg_wr) |=> host_irq[g]);
            p_pulse_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (auto_en[g] && irq_mode && !irq_pol && core_odr_wr[g] && !reg_wr)
                |=> host_irq[g]);
            p_pulse_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (auto_en[g] && irq_mode && !irq_pol && !core_odr_wr[g] && !reg_wr)
                |=> !host_irq[g]);
        end
        for (genvar c = 0; c < NUM_CRQ; c++) begin : g_core
            if (c % 2 == 0) begin : g_obe
                p_obe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    !core_en[c] |-> !core_irq[c]);
            end else begin : g_ibf
                p_ibf_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    !core_en[c] |-> !core_irq[c]);
            end
        end
    endgenerate

endmodule

bind hiic_ctrl hiic_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .core_odr_wr (core_odr_wr),
    .host_odr_rd (host_odr_rd),
    .host_irq    (host_irq),
    .core_irq    (core_irq),
    .auto_en     (auto_en),
    .core_en     (core_en),
    .irq_mode    (irq_mode),
    .irq_pol     (irq_pol)
);

// File: tb/hiic_ctrl_test.sv
`timescale 1ns/1ps
module hiic_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] core_odr_wr = '0;
    logic [2:0] host_odr_rd = '0;
    logic       kbd_obf = 1'b0, kbd_ibf = 1'b0, pm_obf = 1'b0, pm_ibf = 1'b0;
    logic [2:0] host_irq;
    logic [3:0] core_irq;

    always #2 clk = ~clk;   // 250 MHz

    hiic_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_odr_wr(core_odr_wr), .host_odr_rd(host_odr_rd),
        .kbd_obf(kbd_obf), .kbd_ibf(kbd_ibf), .pm_obf(pm_obf), .pm_ibf(pm_ibf),
        .host_irq(host_irq), .core_irq(core_irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    // scoreboard: expected items keyed by cycle; kind 0 rdata, 1 host, 2 core
    int         q_cyc[$];
    int         q_kind[$];
    logic [7:0] q_val[$];
    string      q_req[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            int         k;
            logic [7:0] e, a;
            string      r;
            k = q_kind.pop_front();
            e = q_val.pop_front();
            r = q_req.pop_front();
            void'(q_cyc.pop_front());
            case (k)
                0:       a = reg_rdata;
                1:       a = {5'b0, host_irq};
                default: a = {4'b0, core_irq};
            endcase
            n_checks++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, a, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_val(input int kind, input logic [7:0] v, input string req);
        q_cyc.push_back(cyc);
        q_kind.push_back(kind);
        q_val.push_back(v);
        q_req.push_back(req);
    endtask

    task automatic wreg(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic a, input logic [7:0] v, input string req);
        reg_addr = a;
        expect_val(0, v, req);
    endtask

    task automatic strobe(input logic [2:0] w, input logic [2:0] r);
        core_odr_wr = w; host_odr_rd = r;
        tick();
        core_odr_wr = '0; host_odr_rd = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        rreg(0, 8'h00, "R1 enable reset");
        tick();
        rreg(1, 8'h07, "R2 control reset");
        expect_val(1, 8'h07, "R3 manual lines after reset");
        expect_val(2, 8'h00, "R7 R8 core requests after reset");
        tick();

        wreg(0, 8'hFF); rreg(0, 8'h7F, "R1 bit7 reads zero"); tick();
        wreg(0, 8'h00); rreg(0, 8'h00, "R1 cleared"); tick();
        wreg(1, 8'hFF); rreg(1, 8'h1F, "R2 bits 7:5 ignored"); tick();
        wreg(1, 8'hE5); rreg(1, 8'h05, "R2 write value");
        expect_val(1, 8'h05, "R3 manual 101"); tick();
        wreg(1, 8'h0D); expect_val(1, 8'h02, "R6 manual inverted"); tick();

        // level mode, auto on all three
        wreg(1, 8'h00); wreg(0, 8'h13);
        expect_val(1, 8'h00, "R4 idle level"); tick();
        strobe(3'b001, 3'b000); expect_val(1, 8'h01, "R4 kbd set");
        tick(); tick(); expect_val(1, 8'h01, "R4 kbd held");
        strobe(3'b000, 3'b001); expect_val(1, 8'h00, "R4 kbd cleared by read");
        strobe(3'b110, 3'b000); expect_val(1, 8'h06, "R4 mouse pm set");
        strobe(3'b000, 3'b010); expect_val(1, 8'h04, "R4 mouse read only");
        strobe(3'b000, 3'b100); expect_val(1, 8'h00, "R4 pm read");

        // collision
        strobe(3'b001, 3'b000);
        strobe(3'b001, 3'b001); expect_val(1, 8'h01, "R9 write wins over read");
        strobe(3'b000, 3'b001); expect_val(1, 8'h00, "R9 later read clears");

        // mixed manual/auto
        wreg(0, 8'h01); wreg(1, 8'h06);
        expect_val(1, 8'h06, "R3 mouse pm manual, kbd auto idle");
        strobe(3'b001, 3'b000); expect_val(1, 8'h07, "R3 kbd auto active");
        strobe(3'b000, 3'b001); expect_val(1, 8'h06, "R3 kbd auto cleared");

        // polarity with auto
        wreg(0, 8'h13); wreg(1, 8'h08);
        expect_val(1, 8'h07, "R6 auto idle inverted");
        strobe(3'b001, 3'b000); expect_val(1, 8'h06, "R6 auto active low");
        strobe(3'b000, 3'b001); expect_val(1, 8'h07, "R6 auto released");

        // pulse mode
        wreg(1, 8'h10); expect_val(1, 8'h00, "R5 pulse idle");
        strobe(3'b100, 3'b000); expect_val(1, 8'h04, "R5 pulse high");
        tick(); expect_val(1, 8'h00, "R5 pulse one cycle only");
        strobe(3'b010, 3'b000); strobe(3'b010, 3'b000);
        expect_val(1, 8'h02, "R5 back-to-back pulse");
        tick(); expect_val(1, 8'h00, "R5 back-to-back ends");
        wreg(1, 8'h18); expect_val(1, 8'h07, "R6 pulse idle inverted");
        strobe(3'b001, 3'b000); expect_val(1, 8'h06, "R6 pulse active low");
        tick(); expect_val(1, 8'h07, "R6 pulse ends");
        strobe(3'b000, 3'b111);

        // core requests
        wreg(0, 8'h6C);
        kbd_obf = 1'b0; kbd_ibf = 1'b0; pm_obf = 1'b1; pm_ibf = 1'b1;
        expect_val(2, 8'h09, "R7 R8 pattern a"); tick();
        kbd_obf = 1'b1; kbd_ibf = 1'b1; pm_obf = 1'b0; pm_ibf = 1'b0;
        expect_val(2, 8'h06, "R7 R8 pattern b"); tick();
        wreg(0, 8'h00);
        kbd_obf = 1'b0; kbd_ibf = 1'b1; pm_obf = 1'b0; pm_ibf = 1'b1;
        expect_val(2, 8'h00, "R7 R8 disabled held low"); tick();
        wreg(0, 8'h04); expect_val(2, 8'h01, "R7 kbd empty only"); tick();
        wreg(0, 8'h40); expect_val(2, 8'h08, "R8 pm full only"); tick();

        tick(); tick();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule